// File: doc/BRIEF.md
# Base Address Window Decoder

This block holds the command register, six base address registers and one expansion ROM register of a configuration header. From them it derives validated address windows. Each region has a fixed power-of-two size and a fixed space (I/O or memory), both set by parameters. On a register write the stored value is masked to the bits the region's size allows. The block then works out the effective base of each region and whether the window may decode. It registers the results and presents them as outputs.

A combinational lookup port takes an address and a space select. It returns one hit bit per region whose window is valid, whose space matches, and whose range contains the address. A one-cycle strobe marks every clock edge at which any effective base or valid flag changes, so that downstream decode tables can be refreshed.

Top module: `bar_window_decoder`

## Requirements
- R1: Registers are addressed by dword index on `cfg_idx`. Index 1 is the command register: bits 2:0 are writable and all other bits read 0. Indexes 4 to 9 are base registers 0 to 5, and index 12 is the ROM register. Every other index reads 0, and writes to it change no register and no output.
- R2: A base register keeps only the bits of the write value covered by ~(size-1). On readback, bit 0 shows the space: 1 for I/O and 0 for memory.
- R3: The ROM register is a memory region. Its writable bits are ~(size-1) plus bit 0, and bit 0 is an enable: the ROM window is valid only while bit 0 is 1.
- R4: An I/O window can be valid only while command bit 0 is 1. A memory window, the ROM included, can be valid only while command bit 1 is 1.
- R5: An I/O window is invalid if its effective base is zero, if base+size-1 wraps past the base, or if its last address is 0x10000 or above. A last address of exactly 0xFFFF is allowed.
- R6: A memory window is invalid if its effective base is zero, if its end wraps, or if its last address equals 0xFFFFFFFF.
- R7: The effective base (register value with its low log2(size) bits cleared) and the valid flag of each region appear on `win_base`/`win_valid` one clock edge after the edge that stores the register write. Region i occupies bits 32*i+31:32*i of `win_base`, and the ROM is region 6.
- R8: `win_hit[i]` is 1 in the same cycle exactly when region i is valid, `lk_io` equals the region's space (1 = I/O), and base <= `lk_addr` <= base+size-1.
- R9: `win_chg` is 1 for exactly one cycle, in the cycle in which any effective base or valid flag takes a new value. It is 0 otherwise, including after a write that changes no window.
- R10: After reset all registers are zero, all bases are zero, no window is valid, and `win_chg` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_idx | input | 6 | Dword index for write and readback |
| cfg_wdata | input | 32 | Write value |
| cfg_rdata | output | 32 | Readback of the indexed register |
| lk_addr | input | 32 | Lookup address |
| lk_io | input | 1 | Lookup space: 1 = I/O, 0 = memory |
| win_base | output | 224 | Effective base of each region |
| win_valid | output | 7 | Per-region valid flag |
| win_hit | output | 7 | Per-region lookup hit |
| win_chg | output | 1 | One-cycle change strobe |

## Verification
Lookups are tried at the first and last byte of each window and one byte beyond each end, which separates an off-by-one mask from a correct one. Addresses that match a window's range but come in the other space show whether the space select is honoured. Windows are then moved to zero bases, to a top-of-space memory window and to the edge of the 64K I/O limit. The command bits and the ROM enable are switched one at a time, which shows that each validity rule and each gate acts on its own. Writes that change nothing, or that go to unused indexes, separate a true change strobe from one raised on every write.

// File: rtl/bar_window_decoder.sv
module bar_window_decoder #(
  parameter int NBAR = 6,
  parameter logic [NBAR:0] REG_IS_IO = 7'b0001001,
  parameter logic [5*(NBAR+1)-1:0] REG_LOG2 = {5'd16, 5'd31, 5'd4, 5'd8, 5'd20, 5'd12, 5'd4},
  parameter logic [5:0] CMD_IDX = 6'd1,
  parameter logic [5:0] BAR_IDX0 = 6'd4,
  parameter logic [5:0] ROM_IDX = 6'd12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [5:0]               cfg_idx,
  input  logic [31:0]              cfg_wdata,
  output logic [31:0]              cfg_rdata,
  input  logic [31:0]              lk_addr,
  input  logic                     lk_io,
  output logic [32*(NBAR+1)-1:0]   win_base,
  output logic [NBAR:0]            win_valid,
  output logic [NBAR:0]            win_hit,
  output logic                     win_chg
);
  localparam int NREG = NBAR + 1;
  localparam int ROM = NBAR;

  logic [2:0] cmd_q;
  logic [32*NREG-1:0] base_nx;
  logic [NREG-1:0] valid_nx;
  logic [31:0] rd_arr [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_q <= '0;
    else if (cfg_we && cfg_idx == CMD_IDX) cmd_q <= cfg_wdata[2:0];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [31:0] SZM1 = 32'((64'd1 << REG_LOG2[5*g +: 5]) - 64'd1);
    localparam logic IS_IO = (g == ROM) ? 1'b0 : REG_IS_IO[g];
    localparam logic [31:0] WMASK = ~SZM1 | ((g == ROM) ? 32'd1 : 32'd0);
    localparam logic [5:0] IDX = (g == ROM) ? ROM_IDX : BAR_IDX0 + 6'(g);

    logic [31:0] reg_q;
    logic [31:0] eff;
    logic [32:0] last;
    logic range_ok;
    logic gate;

    always_ff @(posedge clk) begin
      if (!rst_n) reg_q <= '0;
      else if (cfg_we && cfg_idx == IDX) reg_q <= cfg_wdata & WMASK;
    end

    assign rd_arr[g] = (cfg_idx == IDX) ? (reg_q | {31'b0, IS_IO}) : 32'd0;
    assign eff  = reg_q & ~SZM1;
    assign last = {1'b0, eff} + {1'b0, SZM1};

    if (IS_IO) begin : g_io
      assign range_ok = (eff != 0) && !last[32] && (last[31:0] > eff) && (last < 33'h10000);
      assign gate = cmd_q[0];
    end else begin : g_mem
      assign range_ok = (eff != 0) && !last[32] && (last[31:0] > eff) && (last[31:0] != 32'hFFFF_FFFF);
      assign gate = cmd_q[1] && ((g != ROM) || reg_q[0]);
    end

    assign base_nx[32*g +: 32] = eff;
    assign valid_nx[g] = range_ok && gate;
    assign win_hit[g] = win_valid[g] && (lk_io == IS_IO) &&
                        ((lk_addr & ~SZM1) == win_base[32*g +: 32]);

    p_hit_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      win_hit[g] |-> (lk_addr >= win_base[32*g +: 32]) &&
                     ({1'b0, lk_addr} <= {1'b0, win_base[32*g +: 32]} + {1'b0, SZM1}) &&
                     (lk_io == IS_IO));

    if (IS_IO) begin : g_io_chk
      p_io_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid[g] |-> $past(cmd_q[0]));
      p_io_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid[g] |-> (win_base[32*g +: 32] != 0) &&
                         ({1'b0, win_base[32*g +: 32]} + {1'b0, SZM1} < 33'h10000));
    end else begin : g_mem_chk
      p_mem_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid[g] |-> $past(cmd_q[1]));
      p_mem_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid[g] |-> (win_base[32*g +: 32] != 0) &&
                         (win_base[32*g +: 32] + SZM1 != 32'hFFFF_FFFF));
    end

    if (g == ROM) begin : g_rom_chk
      p_rom_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid[g] |-> $past(reg_q[0]));
    end
  end

  always_comb begin
    cfg_rdata = (cfg_idx == CMD_IDX) ? {29'b0, cmd_q} : 32'd0;
    for (int i = 0; i < NREG; i++) cfg_rdata = cfg_rdata | rd_arr[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_base  <= '0;
      win_valid <= '0;
      win_chg   <= 1'b0;
    end else begin
      win_base  <= base_nx;
      win_valid <= valid_nx;
      win_chg   <= (base_nx != win_base) || (valid_nx != win_valid);
    end
  end

  p_chg_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win_chg |-> (win_base != $past(win_base)) || (win_valid != $past(win_valid)));
endmodule

// File: tb/sim_bar_window_decoder.sv
module sim_bar_window_decoder;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0;
  logic [5:0] cfg_idx = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic [31:0] lk_addr = 0;
  logic lk_io = 0;
  logic [223:0] win_base;
  logic [6:0] win_valid, win_hit;
  logic win_chg;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bar_window_decoder u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_addr(lk_addr), .lk_io(lk_io),
    .win_base(win_base), .win_valid(win_valid), .win_hit(win_hit), .win_chg(win_chg));

  // {space, address, expected hit} with regions configured below
  localparam logic [39:0] LKV [14] = '{
    {1'b1, 32'h0000_1000, 7'b0000001},
    {1'b1, 32'h0000_100F, 7'b0000001},
    {1'b1, 32'h0000_1010, 7'b0000000},
    {1'b1, 32'h0000_0FFF, 7'b0000000},
    {1'b1, 32'h0000_FF80, 7'b0001000},
    {1'b1, 32'h0000_FFFF, 7'b0001000},
    {1'b0, 32'h0000_1000, 7'b0000000},
    {1'b0, 32'hFEB0_0FFF, 7'b0000010},
    {1'b0, 32'hFEB0_1000, 7'b0000000},
    {1'b0, 32'h003F_FFFF, 7'b0000100},
    {1'b0, 32'h000C_1234, 7'b1000000},
    {1'b0, 32'h000D_0000, 7'b0000000},
    {1'b0, 32'h9000_0000, 7'b0000000},
    {1'b1, 32'hFEB0_0000, 7'b0000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] idx, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] rd(input logic [5:0] idx);
    cfg_idx = idx;
    return 32'd0;
  endfunction

  task automatic rdchk(input string tag, input logic [5:0] idx, input logic [31:0] exp);
    cfg_idx = idx; #1;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic look(input string tag, input logic io, input logic [31:0] a, input logic [6:0] exp);
    lk_io = io; lk_addr = a; #1;
    chk(tag, {25'b0, win_hit}, {25'b0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 valid", {25'b0, win_valid}, 32'd0);
    chk("R10 chg", {31'b0, win_chg}, 32'd0);
    chk("R10 base", win_base[31:0] | win_base[223:192], 32'd0);
    rdchk("R10 R2 bar0 type", 6'd4, 32'h1);
    rdchk("R10 rom", 6'd12, 32'h0);

    wr(6'd1, 32'h3);
    chk("R9 cmd no window change", {31'b0, win_chg}, 32'd0);
    wr(6'd4, 32'h0000_1003);
    chk("R9 strobe", {31'b0, win_chg}, 32'd1);
    chk("R5 io valid", {31'b0, win_valid[0]}, 32'd1);
    @(negedge clk);
    chk("R9 one cycle", {31'b0, win_chg}, 32'd0);
    wr(6'd5, 32'hFEB0_0ABC);
    wr(6'd6, 32'h0030_0000);
    wr(6'd7, 32'h0000_FF00);
    wr(6'd8, 32'h0);
    wr(6'd9, 32'h8000_0000);
    wr(6'd12, 32'h000C_1235);
    chk("R5 R6 R3 valid set", {25'b0, win_valid}, 32'b1001111);
    rdchk("R2 mem mask", 6'd5, 32'hFEB0_0000);
    rdchk("R2 io type", 6'd4, 32'h0000_1001);
    rdchk("R3 rom mask", 6'd12, 32'h000C_0001);
    chk("R7 base1", win_base[63:32], 32'hFEB0_0000);
    chk("R6 top window base", win_base[191:160], 32'h8000_0000);

    for (int i = 0; i < 14; i++)
      look($sformatf("R8 vec %0d", i), LKV[i][39], LKV[i][38:7], LKV[i][6:0]);

    wr(6'd2, 32'hFFFF_FFFF);
    chk("R1 unused write chg", {31'b0, win_chg}, 32'd0);
    chk("R1 unused write valid", {25'b0, win_valid}, 32'b1001111);
    rdchk("R1 unused read", 6'd2, 32'h0);
    wr(6'd1, 32'hFFFF_FFFF);
    rdchk("R1 cmd readback", 6'd1, 32'h7);
    chk("R1 cmd upper no effect", {25'b0, win_valid}, 32'b1001111);

    wr(6'd1, 32'h2);
    chk("R4 io off", {25'b0, win_valid}, 32'b1000110);
    chk("R4 strobe", {31'b0, win_chg}, 32'd1);
    look("R4 io off hit", 1'b1, 32'h1000, 7'b0);
    wr(6'd1, 32'h1);
    chk("R4 mem off", {25'b0, win_valid}, 32'b0001001);
    look("R4 rom off hit", 1'b0, 32'h000C_1234, 7'b0);
    wr(6'd1, 32'h3);

    wr(6'd12, 32'h000C_0000);
    chk("R3 rom disabled", {31'b0, win_valid[6]}, 32'd0);
    look("R3 rom disabled hit", 1'b0, 32'h000C_1234, 7'b0);

    wr(6'd7, 32'h0001_0000);
    chk("R5 limit invalid", {31'b0, win_valid[3]}, 32'd0);
    chk("R7 base3", win_base[127:96], 32'h0001_0000);
    wr(6'd4, 32'h0000_FFF0);
    chk("R5 last FFFF ok", {31'b0, win_valid[0]}, 32'd1);
    look("R8 io top", 1'b1, 32'h0000_FFF5, 7'b0000001);

    wr(6'd8, 32'h20);
    chk("R6 nonzero valid", {31'b0, win_valid[4]}, 32'd1);
    look("R8 small hit", 1'b0, 32'h2F, 7'b0010000);
    look("R8 small miss", 1'b0, 32'h30, 7'b0);
    wr(6'd9, 32'h8000_0000);
    chk("R9 same value", {31'b0, win_chg}, 32'd0);

    @(negedge clk); cfg_we = 1; cfg_idx = 6'd6; cfg_wdata = 32'h0;
    @(negedge clk); cfg_we = 0;
    chk("R7 not yet", {31'b0, win_valid[2]}, 32'd1);
    @(negedge clk);
    chk("R7 updated", {31'b0, win_valid[2]}, 32'd0);
    chk("R9 strobe late", {31'b0, win_chg}, 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule